// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Modulus Baud Generator

This block turns parallel words into an asynchronous NRZ bit stream on one output line. A modulus counter divides the system clock and produces one bit-time tick every 32 × divisor clocks, with a 13-bit divisor. A divisor of zero stops the counter, so the transmitter stays idle. Frames are 10 bits long (start, eight data bits, stop) or 11 bits long (start, eight data bits, a ninth bit, stop). The ninth bit is either a parity bit or an extra data/control bit taken from the input word.

Words enter through a valid/ready handshake. The frame shape is taken from the control inputs at the moment a word is accepted. There are two other requests. One sends a full frame time of marking ones with no start bit. The other sends a full frame time of zeros with no stop bit. A client sees the line through three outputs: the serial line, a ready flag, and a busy flag that covers the whole frame. Every frame, and every gap between frames, is aligned to the baud ticks.

Top module: `sci_tx`

## Requirements
- R1: Each transmitted bit lasts exactly 32 × `divisor` clock cycles. Two baud ticks are never on adjacent cycles.
- R2: While `divisor` is 0, no baud tick occurs, `tx_ready` is low, `busy` stays low and `txd` stays 1. Once a non-zero divisor is applied, a pending word is sent normally.
- R3: A data frame with `long_frame`=0 is 10 bits: a start bit of 0, then `tx_data[7:0]` least significant bit first, then a stop bit of 1.
- R4: With `long_frame`=1 and `parity_en`=0, a frame is 11 bits. Position 9 (the tenth bit sent, counting the start bit as position 0) carries `tx_data[8]`, and the stop bit follows.
- R5: With `parity_en`=1, the parity bit makes the count of ones over the covered bits plus the parity bit even (`parity_odd`=0) or odd (`parity_odd`=1). With `long_frame`=0 it replaces data bit 7 at position 8 and covers `tx_data[6:0]`. With `long_frame`=1 it sits at position 9 and covers `tx_data[7:0]`.
- R6: An idle request holds `txd` at 1 for one frame time (10 or 11 bit times), and `busy` is high for that whole time.
- R7: A break request holds `txd` at 0 for exactly one frame time (10 or 11 bit times), with no stop bit.
- R8: When requests coincide, break wins over idle, and idle wins over data. A data word is consumed only in a cycle where `tx_valid` and `tx_ready` are high and neither other request is raised, so a word held during a break is sent after it.
- R9: `txd` is 1 after reset and whenever `busy` is low. `busy` is high from the first bit through the last bit. `tx_ready` is high only when no frame is pending or in flight and `divisor` is non-zero.
- R10: A frame starts and ends only at a baud tick. After acceptance, the first bit appears within one bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 13 | Baud modulus; bit time = 32 × divisor clocks, 0 disables |
| long_frame | input | 1 | 0: 10-bit frame, 1: 11-bit frame |
| parity_en | input | 1 | Insert parity bit |
| parity_odd | input | 1 | 0: even parity, 1: odd parity |
| tx_valid | input | 1 | Data word offered |
| tx_data | input | 9 | Word to send; bit 8 used only in 11-bit frames without parity |
| idle_req | input | 1 | Request an all-ones idle frame |
| break_req | input | 1 | Request an all-zeros break frame |
| tx_ready | output | 1 | Transmitter can accept a request |
| txd | output | 1 | Serial line, idles at 1 |
| busy | output | 1 | A frame is on the line |

## Verification
The bound checker checks several rules on every cycle: the line rests high outside a frame, ready excludes busy and a zero divisor, a zero divisor gives no ticks, ticks are never on adjacent cycles, and busy edges align with ticks. Inside a frame it also checks start and stop values, all zeros during a break and all ones during idle. Only the bench scenarios can show the exact bit order and the parity values of each format, the exact bit period for a given divisor, and the frame length of idle and break. The same holds for resumption after the divisor leaves zero and for a held data word surviving a break that overrides it.

// File: rtl/sci_tx_pkg.sv
`timescale 1ns/1ps
package sci_tx_pkg;

  localparam int FRAME_MAX = 11;

  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_IDLE  = 2'd1,
    KIND_BREAK = 2'd2
  } frame_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } shift_state_e;

  // Parity over the bits selected by mask; odd flips the even result.
  function automatic logic parity_of(input logic [7:0] bits,
                                     input logic [7:0] mask,
                                     input logic       odd);
    return (^(bits & mask)) ^ odd;
  endfunction

  function automatic logic [3:0] frame_len(input logic long_f);
    return long_f ? 4'd11 : 4'd10;
  endfunction

  // Bit i of the result is the i-th bit placed on the line.
  function automatic logic [FRAME_MAX-1:0] build_frame(input frame_kind_e kind,
                                                      input logic [8:0] word,
                                                      input logic long_f,
                                                      input logic pen,
                                                      input logic podd);
    logic [FRAME_MAX-1:0] f;
    f = '1;
    case (kind)
      KIND_BREAK: f = '0;
      KIND_IDLE:  f = '1;
      default: begin
        f[0]   = 1'b0;
        f[8:1] = word[7:0];
        if (!long_f) begin
          if (pen) f[8] = parity_of(word[7:0], 8'h7F, podd);
          f[9]  = 1'b1;
          f[10] = 1'b1;
        end else begin
          f[9]  = pen ? parity_of(word[7:0], 8'hFF, podd) : word[8];
          f[10] = 1'b1;
        end
      end
    endcase
    return f;
  endfunction

endpackage

// File: rtl/sci_baud_gen.sv
`timescale 1ns/1ps
module sci_baud_gen #(
  parameter int DIV_W = 13,
  parameter int OSR   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             enable,
  output logic             tick
);
  localparam int OSR_W = $clog2(OSR);
  localparam int CNT_W = DIV_W + OSR_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign enable = (divisor != '0);
  assign limit  = CNT_W'(divisor) * CNT_W'(OSR) - CNT_W'(1);
  assign tick   = enable && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!enable) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/sci_tx_select.sv
`timescale 1ns/1ps
module sci_tx_select
  import sci_tx_pkg::*;
(
  input  logic                 can_accept,
  input  logic                 tx_valid,
  input  logic [8:0]           tx_data,
  input  logic                 idle_req,
  input  logic                 break_req,
  input  logic                 long_frame,
  input  logic                 parity_en,
  input  logic                 parity_odd,
  output logic                 load,
  output frame_kind_e          load_kind,
  output logic [FRAME_MAX-1:0] load_frame,
  output logic [3:0]           load_len
);
  logic any_req;

  assign any_req = tx_valid | idle_req | break_req;
  assign load    = can_accept & any_req;

  always_comb begin
    if (break_req)     load_kind = KIND_BREAK;
    else if (idle_req) load_kind = KIND_IDLE;
    else               load_kind = KIND_DATA;
  end

  assign load_frame = build_frame(load_kind, tx_data, long_frame, parity_en, parity_odd);
  assign load_len   = frame_len(long_frame);
endmodule

// File: rtl/sci_tx_shifter.sv
`timescale 1ns/1ps
module sci_tx_shifter
  import sci_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 load,
  input  frame_kind_e          load_kind,
  input  logic [FRAME_MAX-1:0] load_frame,
  input  logic [3:0]           load_len,
  output logic                 txd,
  output logic                 busy,
  output logic                 idle,
  output frame_kind_e          cur_kind
);
  shift_state_e         state;
  logic [FRAME_MAX-1:0] shreg;
  logic [3:0]           len;
  logic [3:0]           left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '1;
      len      <= 4'd10;
      left     <= '0;
      txd      <= 1'b1;
      cur_kind <= KIND_DATA;
    end else begin
      case (state)
        ST_IDLE: begin
          if (load) begin
            state    <= ST_ARMED;
            shreg    <= load_frame;
            len      <= load_len;
            cur_kind <= load_kind;
          end
        end
        ST_ARMED: begin
          if (tick) begin
            state <= ST_SEND;
            txd   <= shreg[0];
            shreg <= shreg >> 1;
            left  <= len - 4'd1;
          end
        end
        default: begin
          if (tick) begin
            if (left == 4'd0) begin
              state <= ST_IDLE;
              txd   <= 1'b1;
            end else begin
              txd   <= shreg[0];
              shreg <= shreg >> 1;
              left  <= left - 4'd1;
            end
          end
        end
      endcase
    end
  end

  assign busy = (state == ST_SEND);
  assign idle = (state == ST_IDLE);
endmodule

// File: rtl/sci_tx.sv
`timescale 1ns/1ps
module sci_tx
  import sci_tx_pkg::*;
#(
  parameter int DIV_W = 13,
  parameter int OSR   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             long_frame,
  input  logic             parity_en,
  input  logic             parity_odd,
  input  logic             tx_valid,
  input  logic [8:0]       tx_data,
  input  logic             idle_req,
  input  logic             break_req,
  output logic             tx_ready,
  output logic             txd,
  output logic             busy
);
  // Named internal events, visible to the bound checker.
  logic                 baud_tick;
  logic                 baud_on;
  logic                 shifter_idle;
  logic                 load;
  frame_kind_e          load_kind;
  frame_kind_e          cur_kind;
  logic [FRAME_MAX-1:0] load_frame;
  logic [3:0]           load_len;

  sci_baud_gen #(.DIV_W(DIV_W), .OSR(OSR)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (divisor),
    .enable  (baud_on),
    .tick    (baud_tick)
  );

  assign tx_ready = shifter_idle & baud_on;

  sci_tx_select u_select (
    .can_accept (tx_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .idle_req   (idle_req),
    .break_req  (break_req),
    .long_frame (long_frame),
    .parity_en  (parity_en),
    .parity_odd (parity_odd),
    .load       (load),
    .load_kind  (load_kind),
    .load_frame (load_frame),
    .load_len   (load_len)
  );

  sci_tx_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .load       (load),
    .load_kind  (load_kind),
    .load_frame (load_frame),
    .load_len   (load_len),
    .txd        (txd),
    .busy       (busy),
    .idle       (shifter_idle),
    .cur_kind   (cur_kind)
  );
endmodule

// File: rtl/sci_tx_checker.sv
`timescale 1ns/1ps
module sci_tx_checker
  import sci_tx_pkg::*;
#(
  parameter int DIV_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] divisor,
  input logic             tx_ready,
  input logic             txd,
  input logic             busy,
  input logic             baud_tick,
  input frame_kind_e      cur_kind
);
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  p_no_tick_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> !baud_tick);

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && cur_kind == KIND_DATA) |-> !txd);

  p_stop_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && cur_kind == KIND_DATA) |-> $past(txd));

  p_idle_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_kind == KIND_IDLE) |-> txd);

  p_break_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_kind == KIND_BREAK) |-> !txd);

  p_rest_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  p_ready_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!busy && divisor != '0));

  p_start_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(baud_tick));

  p_end_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(baud_tick));
endmodule

bind sci_tx sci_tx_checker #(.DIV_W(DIV_W)) u_sci_tx_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .divisor   (divisor),
  .tx_ready  (tx_ready),
  .txd       (txd),
  .busy      (busy),
  .baud_tick (baud_tick),
  .cur_kind  (cur_kind)
);

// File: tb/test_sci_tx.sv
`timescale 1ns/1ps
module test_sci_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] divisor = 13'd1;
  logic        long_frame = 1'b0, parity_en = 1'b0, parity_odd = 1'b0;
  logic        tx_valid = 1'b0, idle_req = 1'b0, break_req = 1'b0;
  logic [8:0]  tx_data = '0;
  logic        tx_ready, txd, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sci_tx i_sci_tx (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .long_frame(long_frame),
    .parity_en(parity_en), .parity_odd(parity_odd), .tx_valid(tx_valid),
    .tx_data(tx_data), .idle_req(idle_req), .break_req(break_req),
    .tx_ready(tx_ready), .txd(txd), .busy(busy)
  );

  // kind: 0 data, 1 idle, 2 break. exp bit i = i-th bit on the line.
  typedef struct packed {
    logic [1:0]  kind;
    logic        lng;
    logic        pen;
    logic        podd;
    logic [8:0]  data;
    logic [10:0] exp;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 9'h055, {1'b1, 1'b1, 8'h55, 1'b0}},
    '{2'd0, 1'b0, 1'b1, 1'b0, 9'h0A3, {1'b1, 1'b1, 1'b1, 7'h23, 1'b0}},
    '{2'd0, 1'b0, 1'b1, 1'b1, 9'h0A3, {1'b1, 1'b1, 1'b0, 7'h23, 1'b0}},
    '{2'd0, 1'b1, 1'b0, 1'b0, 9'h10F, {1'b1, 1'b1, 8'h0F, 1'b0}},
    '{2'd0, 1'b1, 1'b1, 1'b0, 9'h10F, {1'b1, 1'b0, 8'h0F, 1'b0}},
    '{2'd0, 1'b1, 1'b1, 1'b1, 9'h006, {1'b1, 1'b1, 8'h06, 1'b0}},
    '{2'd0, 1'b1, 1'b0, 1'b0, 9'h0FF, {1'b1, 1'b0, 8'hFF, 1'b0}},
    '{2'd1, 1'b0, 1'b0, 1'b0, 9'h000, 11'h7FF},
    '{2'd2, 1'b1, 1'b0, 1'b0, 9'h000, 11'h000},
    '{2'd2, 1'b0, 1'b0, 1'b0, 9'h000, 11'h000},
    '{2'd1, 1'b1, 1'b0, 1'b0, 9'h000, 11'h7FF}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] kind, input logic lng, input logic pen,
                       input logic podd, input logic [8:0] d);
    @(negedge clk);
    long_frame = lng; parity_en = pen; parity_odd = podd; tx_data = d;
    tx_valid = (kind == 2'd0); idle_req = (kind == 2'd1); break_req = (kind == 2'd2);
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0; idle_req = 1'b0; break_req = 1'b0;
  endtask

  // Samples each bit in the middle of its bit time, then the line after the frame.
  task automatic capture(input int nb, input int per, output logic [10:0] got,
                         output int waited, output logic end_busy, output logic end_txd);
    got = '1;
    waited = 0;
    while (!busy && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    repeat (per / 2) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < nb; i++) begin
      repeat (per) @(negedge clk);
      got[i] = txd;
    end
    repeat (per / 2 + 1) @(negedge clk);
    end_busy = busy;
    end_txd  = txd;
  endtask

  function automatic string req_of(input vec_t v);
    if (v.kind == 2'd2) return "R7";
    if (v.kind == 2'd1) return "R6";
    if (v.pen)          return "R5";
    if (v.lng)          return "R4";
    return "R3";
  endfunction

  task automatic low_run(output int n);
    n = 0;
    while (txd) @(negedge clk);
    while (!txd && n < 100000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [10:0] got;
    logic [10:0] mask;
    int          waited, n, nb;
    logic        eb, et;
    bit          all_high;

    // Reset state (R9)
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R9", "txd in reset", 32'(txd), 32'd1);
    check(busy == 1'b0, "R9", "busy in reset", 32'(busy), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_ready == 1'b1, "R9", "ready after reset", 32'(tx_ready), 32'd1);

    // Vector table, divisor 1 => 32 clocks per bit
    for (int k = 0; k < NVEC; k++) begin
      issue(VEC[k].kind, VEC[k].lng, VEC[k].pen, VEC[k].podd, VEC[k].data);
      nb = VEC[k].lng ? 11 : 10;
      mask = VEC[k].lng ? 11'h7FF : 11'h3FF;
      capture(nb, 32, got, waited, eb, et);
      check((got & mask) == (VEC[k].exp & mask), req_of(VEC[k]), "frame bits",
            32'(got & mask), 32'(VEC[k].exp & mask));
      check(waited <= 32, "R10", "start latency", 32'(waited), 32'd32);
      check(!eb && et, "R9", "line after frame", {30'd0, eb, et}, 32'd1);
    end

    // Zero divisor holds everything (R2)
    @(negedge clk);
    divisor = 13'd0; long_frame = 1'b0; parity_en = 1'b0; tx_data = 9'h000; tx_valid = 1'b1;
    repeat (300) @(negedge clk);
    check(tx_ready == 1'b0, "R2", "ready with zero divisor", 32'(tx_ready), 32'd0);
    check(busy == 1'b0, "R2", "busy with zero divisor", 32'(busy), 32'd0);
    check(txd == 1'b1, "R2", "line with zero divisor", 32'(txd), 32'd1);
    divisor = 13'd1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    capture(10, 32, got, waited, eb, et);
    check(got[9:0] == {1'b1, 8'h00, 1'b0}, "R2", "frame after resume",
          32'(got[9:0]), 32'({1'b1, 8'h00, 1'b0}));

    // Bit period with divisor 2: 0xFE gives two low bit times (R1)
    divisor = 13'd2;
    fork
      issue(2'd0, 1'b0, 1'b0, 1'b0, 9'h0FE);
      low_run(n);
    join
    check(n == 128, "R1", "low run for divisor 2", 32'(n), 32'd128);
    while (busy) @(negedge clk);
    divisor = 13'd1;

    // Idle frame duration (R6)
    issue(2'd1, 1'b0, 1'b0, 1'b0, 9'h000);
    n = 0;
    all_high = 1'b1;
    while (!busy) @(negedge clk);
    while (busy) begin
      if (!txd) all_high = 1'b0;
      n++;
      @(negedge clk);
    end
    check(n == 320, "R6", "idle busy length", 32'(n), 32'd320);
    check(all_high, "R6", "idle line high", 32'(all_high), 32'd1);

    // Break overrides a held data word, which follows afterwards (R8, R7)
    @(negedge clk);
    long_frame = 1'b0; parity_en = 1'b0; tx_data = 9'h03C; tx_valid = 1'b1; break_req = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    break_req = 1'b0;
    low_run(n);
    check(n == 320, "R7", "short break length", 32'(n), 32'd320);
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    capture(10, 32, got, waited, eb, et);
    check(got[9:0] == {1'b1, 8'h3C, 1'b0}, "R8", "held word after break",
          32'(got[9:0]), 32'({1'b1, 8'h3C, 1'b0}));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule